// File: doc/BRIEF.md
# Serial Engine Byte DMA Channel

This block moves one software-described buffer between memory and a serial engine, one byte at a time. Software programs a 64-bit buffer address as two 32-bit halves, an attribute word and a byte count. Writing the byte count starts the transfer. The channel reads the buffer with single-byte requests on a simple memory port, allowing one request in flight at a time. Each returned byte goes to the engine over a valid/ready byte stream.

The channel keeps three sticky status flags: done, end-of-transfer and bus error. An interrupt enable mask is changed only through a write-one-to-set register and a write-one-to-clear register. The interrupt line is high when any enabled status flag is pending. A read-only progress register holds the number of bytes the engine has accepted. The parameter `IS_TX` selects the transmit variant, which is the only one with the end-of-transfer buffer attribute.

Register map (word offsets on `reg_addr`): 0 pointer low, 1 pointer high, 2 attribute, 3 length, 4 enable-set, 5 enable-clear, 6 enable mask (read), 7 status (read, write-one-to-clear), 8 progress count (read). Offsets 4 and 5 read as zero.

Top module: `sedma_channel`

## Requirements
- R1: After reset, every readable register reads 0, and `irq`, `mem_req` and `out_valid` are low.
- R2: Offsets 0 and 1 read back the written pointer halves. Offset 2 keeps bit 0 (end-of-transfer buffer) when `IS_TX`=1. When `IS_TX`=0 offset 2 always reads 0.
- R3: A write to offset 4 ORs `wdata[2:0]` into the enable mask, and a write to offset 5 clears the mask bits that are written as ones. Offset 6 reads the mask. Status and enable bit 0 is done, bit 1 is end-of-transfer and bit 2 is bus error.
- R4: A write of a nonzero count N to offset 3 while idle raises `mem_req` in the next cycle. The channel then requests addresses base, base+1, ..., base+N-1 in that order, with the full 64-bit carry, and has at most one request outstanding.
- R5: Each response byte is presented on `out_data` with `out_valid` held, unchanged, until `out_ready`. The next request is issued only after that byte is accepted.
- R6: When the accepted byte count reaches N, done (bit 0) is set. End-of-transfer (bit 1) is set as well only if the attribute bit was 1 when the transfer started on a TX channel.
- R7: A response with `mem_rsp_err` high ends the transfer. That byte is not forwarded, bus error (bit 2) is set, done stays clear, and the progress count keeps the bytes accepted before the error.
- R8: Offset 8 reads the number of bytes accepted in the current or last transfer. It is cleared when a transfer starts.
- R9: A write to offset 3 while a transfer is active is ignored: the length register and the transfer continue unchanged.
- R10: A count of zero issues no memory request and sets done (plus end-of-transfer under R6) in the cycle after the write.
- R11: A write to offset 7 clears the status bits that are written as ones. Writing all ones clears every pending bit. A new event in the same cycle wins over the clear.
- R12: `irq` is high exactly when some status bit is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Byte read request, held until a response arrives |
| mem_addr | output | 64 | Byte address of the request |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 8 | Response byte |
| mem_rsp_err | input | 1 | Response carries a bus error |
| out_valid | output | 1 | Byte available to the engine |
| out_data | output | 8 | Byte to the engine |
| out_ready | input | 1 | Engine accepts the byte |
| irq | output | 1 | Interrupt line |

## Verification
The properties rely on two assumptions about the memory side. First, `mem_rsp_valid` arrives only while `mem_req` is high. Second, it is a single-cycle pulse. The bench memory model keeps within both: it answers only an observed request, after a programmable delay, and drops the response one cycle later. The properties also assume that the register bus never writes the length while the channel is in the same cycle finishing on its own. The bench's busy-write test hits the middle of a transfer, where this holds.

// File: rtl/sedma_pkg.sv
package sedma_pkg;

  localparam int REG_AW = 4;
  localparam int STAT_W = 3;

  localparam logic [REG_AW-1:0] OFS_PTR_LO  = 4'd0;
  localparam logic [REG_AW-1:0] OFS_PTR_HI  = 4'd1;
  localparam logic [REG_AW-1:0] OFS_ATTR    = 4'd2;
  localparam logic [REG_AW-1:0] OFS_LEN     = 4'd3;
  localparam logic [REG_AW-1:0] OFS_IEN_SET = 4'd4;
  localparam logic [REG_AW-1:0] OFS_IEN_CLR = 4'd5;
  localparam logic [REG_AW-1:0] OFS_IEN     = 4'd6;
  localparam logic [REG_AW-1:0] OFS_STAT    = 4'd7;
  localparam logic [REG_AW-1:0] OFS_PROG    = 4'd8;

  localparam int BIT_DONE = 0;
  localparam int BIT_EOT  = 1;
  localparam int BIT_ERR  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_PUSH} xfer_st_e;

  function automatic logic [63:0] byte_addr(input logic [63:0] base, input logic [31:0] idx);
    return base + {32'd0, idx};
  endfunction

  function automatic logic is_last(input logic [31:0] cnt, input logic [31:0] len);
    return (cnt + 32'd1) == len;
  endfunction

endpackage

// File: rtl/sedma_regs.sv
module sedma_regs
  import sedma_pkg::*;
#(
  parameter bit IS_TX = 1'b1,
  parameter int LEN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  input  logic                busy,
  input  logic [LEN_W-1:0]    len_q,
  input  logic [LEN_W-1:0]    cnt,
  input  logic [STAT_W-1:0]   status,
  output logic [63:0]         base,
  output logic                attr_eot,
  output logic [STAT_W-1:0]   ien,
  output logic                len_wr,
  output logic                arm,
  output logic [STAT_W-1:0]   stat_clr,
  output logic [31:0]         reg_rdata
);

  logic [31:0] ptr_lo, ptr_hi;

  assign base     = {ptr_hi, ptr_lo};
  assign len_wr   = reg_we && (reg_addr == OFS_LEN);
  assign arm      = len_wr && !busy;
  assign stat_clr = (reg_we && reg_addr == OFS_STAT) ? reg_wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_lo <= '0;
      ptr_hi <= '0;
      ien    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_PTR_LO:  ptr_lo <= reg_wdata;
        OFS_PTR_HI:  ptr_hi <= reg_wdata;
        OFS_IEN_SET: ien    <= ien | reg_wdata[STAT_W-1:0];
        OFS_IEN_CLR: ien    <= ien & ~reg_wdata[STAT_W-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (IS_TX) begin : g_tx_attr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             attr_eot <= 1'b0;
        else if (reg_we && reg_addr == OFS_ATTR) attr_eot <= reg_wdata[0];
      end
    end else begin : g_rx_attr
      assign attr_eot = 1'b0;
    end
  endgenerate

  always_comb begin
    case (reg_addr)
      OFS_PTR_LO: reg_rdata = ptr_lo;
      OFS_PTR_HI: reg_rdata = ptr_hi;
      OFS_ATTR:   reg_rdata = {31'd0, attr_eot};
      OFS_LEN:    reg_rdata = 32'(len_q);
      OFS_IEN:    reg_rdata = 32'(ien);
      OFS_STAT:   reg_rdata = 32'(status);
      OFS_PROG:   reg_rdata = 32'(cnt);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sedma_xfer.sv
module sedma_xfer
  import sedma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [LEN_W-1:0]   arm_len,
  input  logic [63:0]        arm_base,
  input  logic               arm_eot,
  output logic               mem_req,
  output logic [63:0]        mem_addr,
  input  logic               mem_rsp_valid,
  input  logic [7:0]         mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               out_valid,
  output logic [7:0]         out_data,
  input  logic               out_ready,
  output logic               busy,
  output logic [LEN_W-1:0]   cnt,
  output logic [LEN_W-1:0]   len_q,
  output logic               beat_ack,
  output logic               ev_done,
  output logic               ev_eot,
  output logic               ev_err
);

  xfer_st_e    state;
  logic [63:0] base_q;
  logic        eot_q;
  logic        last;
  logic        zero_arm;

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_REQ);
  assign out_valid = (state == ST_PUSH);
  assign mem_addr  = byte_addr(base_q, 32'(cnt));
  assign beat_ack  = out_valid && out_ready;
  assign last      = is_last(32'(cnt), 32'(len_q));
  assign zero_arm  = arm && (arm_len == '0);
  assign ev_done   = zero_arm || (beat_ack && last);
  assign ev_eot    = (zero_arm && arm_eot) || (beat_ack && last && eot_q);
  assign ev_err    = mem_req && mem_rsp_valid && mem_rsp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      base_q   <= '0;
      eot_q    <= 1'b0;
      cnt      <= '0;
      len_q    <= '0;
      out_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (arm) begin
          base_q <= arm_base;
          eot_q  <= arm_eot;
          len_q  <= arm_len;
          cnt    <= '0;
          state  <= zero_arm ? ST_IDLE : ST_REQ;
        end
        ST_REQ: if (mem_rsp_valid) begin
          if (mem_rsp_err) state <= ST_IDLE;
          else begin
            out_data <= mem_rsp_data;
            state    <= ST_PUSH;
          end
        end
        ST_PUSH: if (out_ready) begin
          cnt   <= cnt + 1'b1;
          state <= last ? ST_IDLE : ST_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sedma_irq.sv
module sedma_irq
  import sedma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_set,
  input  logic [STAT_W-1:0] stat_clr,
  input  logic [STAT_W-1:0] ien,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~stat_clr) | ev_set;
  end

  assign irq = |(status & ien);

endmodule

// File: rtl/sedma_channel.sv
module sedma_channel
  import sedma_pkg::*;
#(
  parameter bit IS_TX = 1'b1,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              irq
);

  logic [63:0]        base;
  logic               attr_eot;
  logic [STAT_W-1:0]  ien, status, stat_clr, ev_set;
  logic               len_wr, arm_pulse, busy, beat_ack;
  logic               ev_done, ev_eot, ev_err;
  logic [LEN_W-1:0]   cnt, len_q;

  sedma_regs #(.IS_TX(IS_TX), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .len_q(len_q), .cnt(cnt), .status(status),
    .base(base), .attr_eot(attr_eot), .ien(ien), .len_wr(len_wr), .arm(arm_pulse),
    .stat_clr(stat_clr), .reg_rdata(reg_rdata)
  );

  sedma_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .arm(arm_pulse), .arm_len(reg_wdata[LEN_W-1:0]),
    .arm_base(base), .arm_eot(attr_eot),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .cnt(cnt), .len_q(len_q), .beat_ack(beat_ack),
    .ev_done(ev_done), .ev_eot(ev_eot), .ev_err(ev_err)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[BIT_DONE] = ev_done;
    ev_set[BIT_EOT]  = ev_eot;
    ev_set[BIT_ERR]  = ev_err;
  end

  sedma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .stat_clr(stat_clr),
    .ien(ien), .status(status), .irq(irq)
  );

endmodule

// File: rtl/sedma_channel_chk.sv
module sedma_channel_chk
  import sedma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_pulse,
  input logic              len_wr,
  input logic              busy,
  input logic [LEN_W-1:0]  reg_len,
  input logic [LEN_W-1:0]  len_q,
  input logic [LEN_W-1:0]  cnt,
  input logic              mem_req,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_ready,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] ien,
  input logic              irq
);

  AST_ARM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse && reg_len != '0 |=> mem_req); // R4

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse && reg_len == '0 |=> status[BIT_DONE] && !mem_req); // R10

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && out_valid)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5

  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rsp_valid && mem_rsp_err |=> !mem_req && !out_valid && status[BIT_ERR]); // R7

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr && busy |=> $stable(len_q)); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < len_q); // R8

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != '0 && ien != '0); // R12

endmodule

bind sedma_channel sedma_channel_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_pulse(arm_pulse), .len_wr(len_wr), .busy(busy),
  .reg_len(reg_wdata[LEN_W-1:0]), .len_q(len_q), .cnt(cnt),
  .mem_req(mem_req), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .status(status), .ien(ien), .irq(irq)
);

// File: tb/test_sedma_channel.sv
module test_sedma_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, rx_rdata;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        irq;
  logic        rx_mem_req, rx_out_valid, rx_irq;
  logic [63:0] rx_mem_addr;
  logic [7:0]  rx_out_data;

  int checks = 0;
  int errors = 0;

  // test state shared with the memory and sink models
  logic [63:0] exp_base = '0;
  int req_idx = 0, got = 0, lat = 0, wait_cnt = 0, stall = 0, cyc = 0;
  int err_at = -1;
  logic pend = 1'b0;
  logic [7:0] pend_d = '0;

  always #10 clk = ~clk;

  sedma_channel #(.IS_TX(1'b1), .LEN_W(16)) i_sedma_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .irq(irq)
  );

  sedma_channel #(.IS_TX(1'b0), .LEN_W(16)) i_sedma_channel_rx (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rx_rdata), .mem_req(rx_mem_req), .mem_addr(rx_mem_addr),
    .mem_rsp_valid(1'b0), .mem_rsp_data(8'd0), .mem_rsp_err(1'b0),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .out_ready(1'b1), .irq(rx_irq)
  );

  function automatic logic [7:0] pat(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ a[39:32] ^ 8'hA5;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // memory model and byte sink, both acting at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (pend) begin
      chk(out_data_ok(pend_d), "R5 byte value", {56'd0, pend_d}, {56'd0, pat(exp_base + 64'(got))});
      got++;
    end
    case (stall)
      1:       out_ready = cyc[0];
      2:       out_ready = (cyc % 3) == 2;
      default: out_ready = 1'b1;
    endcase
    pend   = out_valid && out_ready;
    pend_d = out_data;
    if (mem_rsp_valid) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt < lat) wait_cnt++;
      else begin
        wait_cnt = 0;
        chk(mem_addr == exp_base + 64'(req_idx), "R4 request address", mem_addr, exp_base + 64'(req_idx));
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pat(mem_addr);
        mem_rsp_err   = (req_idx == err_at);
        req_idx++;
      end
    end
  end

  function automatic logic out_data_ok(input logic [7:0] d);
    return d == pat(exp_base + 64'(got));
  endfunction

  task automatic wait_end();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(4'd7, s);
      if (s[0] || s[2]) break;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [63:0] base, input int len, input bit eot, input int l,
                     input int st, input int e_at);
    logic [31:0] s, p;
    int nb;
    exp_base = base; req_idx = 0; got = 0; lat = l; wait_cnt = 0; stall = st; err_at = e_at;
    wr(4'd0, base[31:0]);
    wr(4'd1, base[63:32]);
    wr(4'd2, {31'd0, eot});
    wr(4'd3, 32'(len));
    wait_end();
    rd(4'd7, s);
    rd(4'd8, p);
    if (e_at >= 0 && e_at < len) begin
      nb = e_at;
      chk(s == 32'd4, "R7 status after error", 64'(s), 64'd4);
      chk(p == 32'(nb), "R7 progress after error", 64'(p), 64'(nb));
    end else begin
      nb = len;
      chk(s == {30'd0, eot, 1'b1}, "R6 status after transfer", 64'(s), {62'd0, eot, 1'b1});
      chk(p == 32'(nb), "R8 progress count", 64'(p), 64'(nb));
    end
    chk(got == nb, "R5 bytes delivered", 64'(got), 64'(nb));
    chk(req_idx == ((e_at >= 0 && e_at < len) ? e_at + 1 : len), "R4 request count",
        64'(req_idx), 64'((e_at >= 0 && e_at < len) ? e_at + 1 : len));
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, s);
    chk(s == 32'd0, "R11 status cleared by all ones", 64'(s), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      chk(v == 32'd0, "R1 register reset value", 64'(v), 64'd0);
    end
    chk(!irq && !mem_req && !out_valid, "R1 outputs idle", {61'd0, irq, mem_req, out_valid}, 64'd0);

    // R2 pointer and attribute readback, RX has no attribute bit
    wr(4'd0, 32'hDEAD_BEEF);
    wr(4'd1, 32'h0123_4567);
    rd(4'd0, v); chk(v == 32'hDEAD_BEEF, "R2 pointer low", 64'(v), 64'hDEAD_BEEF);
    rd(4'd1, v); chk(v == 32'h0123_4567, "R2 pointer high", 64'(v), 64'h0123_4567);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, v); chk(v == 32'd1, "R2 TX attribute", 64'(v), 64'd1);
    chk(rx_rdata == 32'd0, "R2 RX attribute reads zero", 64'(rx_rdata), 64'd0);

    // R10 zero length on both channels, R6 end-of-transfer only on TX
    wr(4'd3, 32'd0);
    rd(4'd7, v);
    chk(v == 32'd3, "R10 TX zero length done and eot", 64'(v), 64'd3);
    chk(rx_rdata == 32'd1, "R6 RX zero length done without eot", 64'(rx_rdata), 64'd1);
    chk(!mem_req && !rx_mem_req, "R10 no request for zero length", {62'd0, mem_req, rx_mem_req}, 64'd0);
    wr(4'd7, 32'h0000_0002);
    rd(4'd7, v);
    chk(v == 32'd1, "R11 partial clear", 64'(v), 64'd1);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, v);
    chk(v == 32'd0, "R11 all ones clear", 64'(v), 64'd0);

    // R3 enable set and clear
    wr(4'd4, 32'h0000_0005);
    rd(4'd6, v); chk(v == 32'd5, "R3 enable set", 64'(v), 64'd5);
    wr(4'd4, 32'h0000_0002);
    rd(4'd6, v); chk(v == 32'd7, "R3 enable set ORs", 64'(v), 64'd7);
    wr(4'd5, 32'h0000_0006);
    rd(4'd6, v); chk(v == 32'd1, "R3 enable clear", 64'(v), 64'd1);
    rd(4'd4, v); chk(v == 32'd0, "R3 set offset reads zero", 64'(v), 64'd0);

    // R4 R5 R6 R8 sweep: lengths, latencies, stall patterns, attribute
    for (int n = 0; n < 6; n++)
      for (int l = 0; l < 3; l++)
        for (int st = 0; st < 3; st++)
          for (int e = 0; e < 2; e++)
            run({32'h0000_1230 + 32'(n), 32'hFFFF_FFFD}, n, e[0], l, st, -1);

    // R7 error at each position
    for (int k = 0; k < 4; k++)
      run(64'h0000_0040_0000_0100 + 64'(k), 4, 1'b1, k % 2, k % 3, k);

    // R12 interrupt: enable = done only
    wr(4'd0, 32'h10); wr(4'd1, 32'h0); wr(4'd2, 32'h0);
    exp_base = 64'h10; req_idx = 0; got = 0; lat = 0; stall = 0; err_at = -1;
    wr(4'd3, 32'd1);
    wait_end();
    chk(irq == 1'b1, "R12 irq with done enabled", {63'd0, irq}, 64'd1);
    wr(4'd5, 32'h1);
    chk(irq == 1'b0, "R12 irq masked by clear", {63'd0, irq}, 64'd0);
    wr(4'd4, 32'h4);
    chk(irq == 1'b0, "R12 irq off with other enable", {63'd0, irq}, 64'd0);
    wr(4'd7, 32'h1);
    // error raises irq through bus error enable
    exp_base = 64'h10; req_idx = 0; got = 0; err_at = 0;
    wr(4'd3, 32'd2);
    wait_end();
    chk(irq == 1'b1, "R12 irq on bus error", {63'd0, irq}, 64'd1);
    wr(4'd7, 32'hFFFF_FFFF);
    chk(irq == 1'b0, "R12 irq low after clear", {63'd0, irq}, 64'd0);

    // R9 length write while active is ignored
    exp_base = 64'h200; req_idx = 0; got = 0; lat = 3; stall = 1; err_at = -1;
    wr(4'd0, 32'h200); wr(4'd1, 32'h0);
    wr(4'd3, 32'd4);
    repeat (3) @(negedge clk);
    wr(4'd3, 32'd1);
    rd(4'd3, v); chk(v == 32'd4, "R9 length unchanged while busy", 64'(v), 64'd4);
    wait_end();
    rd(4'd8, v); chk(v == 32'd4, "R9 transfer ran to full length", 64'(v), 64'd4);
    chk(got == 4, "R9 bytes delivered", 64'(got), 64'd4);
    wr(4'd7, 32'hFFFF_FFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule